// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial-peripheral-interface master driven through a small 32-bit register window. Software programs a control word that gives the idle clock level, the clock edge on which each data bit is driven out, the edge on which the incoming bit is sampled, the bit order, a word length of 1 to 32 bits, a word count of 1 to 4, and an idle gap between words. It also programs a clock divider, a chip-select register and a transmit word. Setting the go bit then runs one burst.

During the burst the go bit reads back as busy and the configuration is frozen. At the end of the burst a completion flag is set, the most recently received word appears at the data offset, and a level interrupt is raised if it is enabled. Software acknowledges the burst by writing back the control value it read, because the flag bit clears when a 1 is written to it. The next burst can be started at once.

Top module: `spi_regmaster`

## Requirements
- R1: After reset the control word (offset 0x00), the divider (0x04), the select register (0x08) and the receive word (0x10) all read 0, the serial clock is 0, the interrupt is 0 and the chip-select pin is 1.
- R2: Offsets are decoded as control 0x00, divider 0x04, select 0x08 and data 0x10. A write to 0x10 sets the transmit word, and a read of 0x10 returns the last received word, not the transmit word.
- R3: The serial clock sits at control bit 31 whenever the block is idle or in a gap between words. While a word is shifting, each half period of the serial clock lasts divider+1 system clocks.
- R4: Writing control with bit 0 set while idle starts a burst at that clock edge. Bit 0 then reads 1 until the clock edge that ends the final bit period, and reads 0 from that edge on.
- R5: The word length is control bits 7:3, where 0 means 32 bits and any other value n means n bits. Each word has exactly that many serial clock periods.
- R6: Control bit 10 selects the order. When it is 1 the transmit bit 0 goes out first and the first received bit lands in receive bit 0. When it is 0 the transmit bit length-1 goes out first and the first received bit lands in receive bit length-1. Received bits at or above the length read 0.
- R7: Control bit 1 = 1 samples the input on falling serial clock edges (rising when 0). Control bit 2 = 1 drives the output on falling edges (rising when 0). The first bit is presented before the first edge. After a drive edge the output shows the bit whose index equals the number of samples taken so far in the word.
- R8: Control bits 9:8 = k give k+1 words per burst. Every word sends the same transmit word. Consecutive words are separated by (bits 15:12 + 1) serial clock periods of idle clock, and the data offset holds the last word received.
- R9: The completion flag (control bit 16) is set on the edge where busy falls. The interrupt output is high exactly when the flag and control bit 17 are both 1.
- R10: Writing control with bit 16 = 1 clears the flag, and writing it with bit 16 = 0 leaves the flag unchanged. A burst can be started by the write that clears the flag.
- R11: While busy, writes to the control fields, the divider and the transmit word are ignored, and the running burst keeps its original settings.
- R12: The select register holds bit 0 (assert) and bit 2 (active level). The chip-select pin equals the level when asserted and its inverse otherwise, and the register may be written at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip select |
| irq | output | 1 | Level interrupt |

## Verification
Bursts are run under five settings: both polarities; drive and sample on opposite edges in each phase order; drive and sample on the same edge, both rising and falling; both bit orders; lengths of 4, 5, 8, 12 and the 32-bit encoding 0; and a three-word burst with a gap. A behavioural slave in the bench shifts a known pattern back and records what it receives. A wrong drive index or edge choice therefore shows up as a corrupted word on one side, and a bit-order error shows up as a mirrored word. An arithmetic timing model predicts the serial clock, busy and interrupt on every cycle, so errors in the divider, the gap or the word length appear as a mismatch at a known cycle. Writes made during a running burst, followed by readback and by the slave's captures, separate frozen settings from leaked ones.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

    localparam int REG_W  = 32;
    localparam int LEN_W  = 5;
    localparam int CNT_W  = LEN_W + 1;
    localparam int GAP_W  = 5;

    localparam int OFS_CTRL = 'h00;
    localparam int OFS_DIV  = 'h04;
    localparam int OFS_SEL  = 'h08;
    localparam int OFS_DATA = 'h10;

    // bit positions of the control word that software and engine agree on
    localparam int B_GO     = 0;
    localparam int B_FLAG   = 16;

    typedef struct packed {
        logic             cpol;
        logic             ie;
        logic [3:0]       sleep;
        logic             lsb;
        logic [1:0]       words;
        logic [LEN_W-1:0] len;
        logic             launch_fall;
        logic             cap_fall;
    } xfer_cfg_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_GAP
    } eng_state_t;

    // field value 0 encodes the full register width
    function automatic logic [CNT_W-1:0] bits_in_word(input logic [LEN_W-1:0] f);
        return (f == '0) ? CNT_W'(REG_W) : {1'b0, f};
    endfunction

    // register bit that carries the idx-th serial bit of a word
    function automatic logic [LEN_W-1:0] bit_slot(input logic [CNT_W-1:0] idx,
                                                  input logic [CNT_W-1:0] nbits,
                                                  input logic             lsb);
        logic [CNT_W-1:0] p;
        p = lsb ? idx : (nbits - CNT_W'(1) - idx);
        return p[LEN_W-1:0];
    endfunction

endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
    import spi_rm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DIV_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [REG_W-1:0]      wdata,
    output logic [REG_W-1:0]      rdata,
    input  logic                  busy,
    input  logic                  done,
    input  logic                  rx_load,
    input  logic [REG_W-1:0]      rx_word,
    output xfer_cfg_t             cfg,
    output logic [DIV_W-1:0]      div,
    output logic [REG_W-1:0]      txword,
    output logic                  sel_en,
    output logic                  sel_lvl,
    output logic                  start,
    output logic                  flag,
    output logic                  irq
);

    logic [REG_W-1:0] rxbuf;
    logic             hit_ctrl, hit_div, hit_sel, hit_data;

    assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
    assign hit_div  = (addr == ADDR_W'(OFS_DIV));
    assign hit_sel  = (addr == ADDR_W'(OFS_SEL));
    assign hit_data = (addr == ADDR_W'(OFS_DATA));

    assign start = we && hit_ctrl && wdata[B_GO] && !busy;
    assign irq   = flag && cfg.ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            div     <= '0;
            txword  <= '0;
            rxbuf   <= '0;
            sel_en  <= 1'b0;
            sel_lvl <= 1'b0;
            flag    <= 1'b0;
        end else begin
            if (done) begin
                flag <= 1'b1;
            end else if (we && hit_ctrl && wdata[B_FLAG]) begin
                flag <= 1'b0;
            end
            if (rx_load) begin
                rxbuf <= rx_word;
            end
            if (we && hit_sel) begin
                sel_en  <= wdata[0];
                sel_lvl <= wdata[2];
            end
            if (we && !busy) begin
                if (hit_ctrl) begin
                    cfg.cap_fall    <= wdata[1];
                    cfg.launch_fall <= wdata[2];
                    cfg.len         <= wdata[7:3];
                    cfg.words       <= wdata[9:8];
                    cfg.lsb         <= wdata[10];
                    cfg.sleep       <= wdata[15:12];
                    cfg.ie          <= wdata[17];
                    cfg.cpol        <= wdata[31];
                end
                if (hit_div) begin
                    div <= wdata[DIV_W-1:0];
                end
                if (hit_data) begin
                    txword <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_ctrl) begin
            rdata[0]     = busy;
            rdata[1]     = cfg.cap_fall;
            rdata[2]     = cfg.launch_fall;
            rdata[7:3]   = cfg.len;
            rdata[9:8]   = cfg.words;
            rdata[10]    = cfg.lsb;
            rdata[15:12] = cfg.sleep;
            rdata[16]    = flag;
            rdata[17]    = cfg.ie;
            rdata[31]    = cfg.cpol;
        end else if (hit_div) begin
            rdata = REG_W'(div);
        end else if (hit_sel) begin
            rdata[0] = sel_en;
            rdata[2] = sel_lvl;
        end else if (hit_data) begin
            rdata = rxbuf;
        end
    end

endmodule

// File: rtl/spi_rm_clkdiv.sv
module spi_rm_clkdiv #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] hcnt;

    assign tick = run && (hcnt == div);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt <= '0;
        end else if (tick) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine
    import spi_rm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tick,
    input  xfer_cfg_t        cfg,
    input  logic [REG_W-1:0] txword,
    input  logic             miso,
    output logic             busy,
    output logic             sclk,
    output logic             mosi,
    output logic             done,
    output logic             rx_load,
    output logic [REG_W-1:0] rx_word
);

    eng_state_t       state;
    logic             half;
    logic [CNT_W-1:0] pcnt, ccnt, ccnt_n, midx, nbits;
    logic [1:0]       wcnt;
    logic [GAP_W-1:0] gcnt;
    logic [REG_W-1:0] rx_acc, rx_n;
    logic             shifting, first_half, cap_e1, launch_e1;
    logic             cap_now, launch_now, word_end, last_word, gap_end;

    always_comb begin
        nbits      = bits_in_word(cfg.len);
        shifting   = (state == ENG_SHIFT);
        first_half = !half;
        cap_e1     = (cfg.cap_fall == cfg.cpol);
        launch_e1  = (cfg.launch_fall == cfg.cpol);
        cap_now    = shifting && tick && (first_half == cap_e1);
        launch_now = shifting && tick && (first_half == launch_e1);
        ccnt_n     = ccnt + CNT_W'(cap_now);
        rx_n       = rx_acc;
        if (cap_now) begin
            rx_n[bit_slot(ccnt, nbits, cfg.lsb)] = miso;
        end
        word_end   = shifting && tick && !first_half && (pcnt == nbits - CNT_W'(1));
        last_word  = (wcnt == cfg.words);
        gap_end    = (state == ENG_GAP) && tick && (gcnt == {cfg.sleep, 1'b1});
    end

    assign busy    = (state != ENG_IDLE);
    assign sclk    = shifting ? (cfg.cpol ^ half) : cfg.cpol;
    assign mosi    = txword[bit_slot(midx, nbits, cfg.lsb)];
    assign done    = word_end && last_word;
    assign rx_load = word_end;
    assign rx_word = rx_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            half   <= 1'b0;
            pcnt   <= '0;
            ccnt   <= '0;
            midx   <= '0;
            wcnt   <= '0;
            gcnt   <= '0;
            rx_acc <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state  <= ENG_SHIFT;
                        half   <= 1'b0;
                        pcnt   <= '0;
                        ccnt   <= '0;
                        midx   <= '0;
                        wcnt   <= '0;
                        rx_acc <= '0;
                    end
                end
                ENG_SHIFT: begin
                    if (tick) begin
                        half   <= ~half;
                        ccnt   <= ccnt_n;
                        rx_acc <= rx_n;
                        if (launch_now && (ccnt_n < nbits)) begin
                            midx <= ccnt_n;
                        end
                        if (!first_half) begin
                            pcnt <= pcnt + CNT_W'(1);
                        end
                        if (word_end) begin
                            state <= last_word ? ENG_IDLE : ENG_GAP;
                            gcnt  <= '0;
                        end
                    end
                end
                ENG_GAP: begin
                    if (gap_end) begin
                        state  <= ENG_SHIFT;
                        half   <= 1'b0;
                        pcnt   <= '0;
                        ccnt   <= '0;
                        midx   <= '0;
                        rx_acc <= '0;
                        wcnt   <= wcnt + 2'd1;
                    end else if (tick) begin
                        gcnt <= gcnt + GAP_W'(1);
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
    import spi_rm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs,
    output logic              irq
);

    xfer_cfg_t        cfg_w;
    logic [DIV_W-1:0] div_w;
    logic [REG_W-1:0] tx_w, rx_w;
    logic             busy_w, done_w, rxld_w, start_w, tick_w;
    logic             sel_en_w, sel_lvl_w, flag_w;

    spi_rm_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .busy    (busy_w),
        .done    (done_w),
        .rx_load (rxld_w),
        .rx_word (rx_w),
        .cfg     (cfg_w),
        .div     (div_w),
        .txword  (tx_w),
        .sel_en  (sel_en_w),
        .sel_lvl (sel_lvl_w),
        .start   (start_w),
        .flag    (flag_w),
        .irq     (irq)
    );

    spi_rm_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_w),
        .div  (div_w),
        .tick (tick_w)
    );

    spi_rm_engine engine_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start_w),
        .tick    (tick_w),
        .cfg     (cfg_w),
        .txword  (tx_w),
        .miso    (spi_miso),
        .busy    (busy_w),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (done_w),
        .rx_load (rxld_w),
        .rx_word (rx_w)
    );

    assign spi_cs = sel_en_w ? sel_lvl_w : ~sel_lvl_w;

endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk
    import spi_rm_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             flag,
    input logic             sclk,
    input xfer_cfg_t        cfg,
    input logic [DIV_W-1:0] div,
    input logic             sel_en,
    input logic             sel_lvl,
    input logic             cs
);

    AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cfg.cpol)); // R3

    AST_FLAG_ON_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> flag); // R9

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg)); // R11

    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(div)); // R11

    AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($stable(sel_en) && $stable(sel_lvl)) |-> $stable(cs)); // R12

endmodule

bind spi_regmaster spi_regmaster_chk #(.DIV_W(DIV_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy_w),
    .flag    (flag_w),
    .sclk    (spi_sclk),
    .cfg     (cfg_w),
    .div     (div_w),
    .sel_en  (sel_en_w),
    .sel_lvl (sel_lvl_w),
    .cs      (spi_cs)
);

// File: tb/spi_regmaster_tb_top.sv
module spi_regmaster_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;
    localparam int WDOG       = 150000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              sclk, mosi, miso, cs, irq;

    spi_regmaster #(.ADDR_W(ADDR_W), .DIV_W(16)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sclk  (sclk),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .spi_cs    (cs),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // counters: initial-block checks, monitor checks
    int chk_i = 0, bad_i = 0, chk_m = 0, bad_m = 0;

    // slave and model settings written only by the stimulus
    bit          s_on = 0, s_capf = 0, s_lsb = 0;
    int          s_len = 8;
    logic [31:0] s_pat = '0, s_tx = '0;
    bit          m_on = 0, m_cpol = 0, m_ie = 0;
    int          m_t0 = 0, m_h = 1, m_w = 1, m_g = 0, m_end = 0;

    // slave and monitor state written only by the monitor
    bit          s_was = 0, s_psclk = 0, s_pmosi = 0;
    int          s_idx = 0, s_got = 0;
    logic [31:0] s_rx = '0;

    function automatic int slot(input int j, input int n, input bit l);
        return l ? j : n - 1 - j;
    endfunction

    function automatic logic [31:0] lmask(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    assign miso = s_pat[slot(s_idx, s_len, s_lsb)];

    always @(negedge clk) begin
        if (s_on && !s_was) begin
            s_idx = 0;
            s_rx  = '0;
            s_got = 0;
        end else if (s_on && (sclk != s_psclk) && ((sclk == 1'b0) == s_capf)) begin
            s_rx[slot(s_idx, s_len, s_lsb)] = s_pmosi;
            s_idx = s_idx + 1;
            if (s_idx == s_len) begin
                s_got = s_got + 1;
                chk_m = chk_m + 1;
                if (s_rx != (s_tx & lmask(s_len))) begin
                    bad_m = bad_m + 1;
                    $display("FAIL R7 slave word %0d act=%h exp=%h", s_got, s_rx, s_tx & lmask(s_len));
                end
                s_idx = 0;
                s_rx  = '0;
            end
        end
        s_was   = s_on;
        s_psclk = sclk;
        s_pmosi = mosi;
        if (m_on) begin
            int  c, r;
            bit  eb, es, ei;
            c  = cyc - m_t0;
            eb = (c < m_end);
            es = m_cpol;
            if (eb) begin
                r = c % (m_w + m_g);
                if (r < m_w) es = m_cpol ^ (((r / m_h) % 2) == 1);
            end
            ei = !eb && m_ie;
            chk_m = chk_m + 2;
            if (sclk != es) begin
                bad_m = bad_m + 1;
                $display("FAIL R3 sclk at c=%0d act=%0b exp=%0b", c, sclk, es);
            end
            if (irq != ei) begin
                bad_m = bad_m + 1;
                $display("FAIL R9 irq at c=%0d act=%0b exp=%0b", c, irq, ei);
            end
            if (!reg_we && reg_addr == '0) begin
                chk_m = chk_m + 1;
                if (reg_rdata[0] != eb) begin
                    bad_m = bad_m + 1;
                    $display("FAIL R4 busy at c=%0d act=%0b exp=%0b", c, reg_rdata[0], eb);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        chk_i = chk_i + 1;
        if (!ok) begin
            bad_i = bad_i + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = ADDR_W'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
        reg_addr  = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = ADDR_W'(a);
        #1;
        d = reg_rdata;
        reg_addr = '0;
    endtask

    function automatic logic [31:0] ctrl_word(input bit cpol, input bit ie, input bit fclr,
                                              input logic [3:0] slp, input bit lsb,
                                              input logic [1:0] words, input logic [4:0] len,
                                              input bit lauf, input bit capf, input bit go);
        logic [31:0] v;
        v = '0;
        v[31] = cpol; v[17] = ie; v[16] = fclr; v[15:12] = slp; v[10] = lsb;
        v[9:8] = words; v[7:3] = len; v[2] = lauf; v[1] = capf; v[0] = go;
        return v;
    endfunction

    task automatic run_xfer(input string tag, input bit cpol, input bit capf, input bit lauf,
                            input logic [4:0] len, input logic [1:0] words, input logic [3:0] slp,
                            input bit lsb, input logic [15:0] dv, input logic [31:0] tx,
                            input logic [31:0] pat, input bit ie, input bit poke);
        logic [31:0] v;
        int n, nw;
        n  = (len == 0) ? 32 : int'(len);
        nw = int'(words) + 1;
        s_on = 0;
        @(negedge clk);
        s_len = n; s_lsb = lsb; s_capf = capf; s_pat = pat; s_tx = tx;
        m_cpol = cpol; m_ie = ie; m_h = int'(dv) + 1;
        m_w = 2 * n * m_h; m_g = 2 * (int'(slp) + 1) * m_h;
        m_end = nw * m_w + (nw - 1) * m_g;
        wr('h04, {16'd0, dv});
        wr('h10, tx);
        wr('h00, ctrl_word(cpol, ie, 1, slp, lsb, words, len, lauf, capf, 0));
        s_on = 1;
        @(negedge clk);
        @(negedge clk);
        wr('h00, ctrl_word(cpol, ie, 1, slp, lsb, words, len, lauf, capf, 1));
        m_t0 = cyc;
        m_on = 1;
        if (poke) begin
            // R11: these writes land while busy and must change nothing
            wr('h04, 32'd7);
            wr('h00, ctrl_word(!cpol, !ie, 0, 4'd9, !lsb, 2'd0, 5'd9, !lauf, !capf, 1));
            wr('h10, ~tx);
        end
        while ((cyc - m_t0) <= m_end + 1) @(negedge clk);
        m_on = 0;
        rd('h10, v);
        chk(v == (pat & lmask(n)), {tag, " R6 received word"}, v, pat & lmask(n));
        chk(s_got == nw, {tag, " R8 word count"}, 32'(s_got), 32'(nw));
        chk(irq == ie, {tag, " R9 irq after burst"}, {31'd0, irq}, {31'd0, ie});
        rd('h00, v);
        chk(v == ctrl_word(cpol, ie, 1, slp, lsb, words, len, lauf, capf, 0),
            {tag, " R11 control readback"}, v, ctrl_word(cpol, ie, 1, slp, lsb, words, len, lauf, capf, 0));
        rd('h04, v);
        chk(v == {16'd0, dv}, {tag, " R11 divider readback"}, v, {16'd0, dv});
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd('h00, v); chk(v == 0, "R1 control", v, 0);
        rd('h04, v); chk(v == 0, "R1 divider", v, 0);
        rd('h08, v); chk(v == 0, "R1 select", v, 0);
        rd('h10, v); chk(v == 0, "R1 data", v, 0);
        chk(sclk == 0, "R1 sclk", {31'd0, sclk}, 0);
        chk(irq == 0, "R1 irq", {31'd0, irq}, 0);
        chk(cs == 1, "R1 cs", {31'd0, cs}, 1);
        // R2 map and R12 select
        wr('h04, 32'd3); rd('h04, v); chk(v == 3, "R2 divider", v, 3);
        wr('h10, 32'hA5); rd('h10, v); chk(v == 0, "R2 data reads receive side", v, 0);
        wr('h08, 32'h5); rd('h08, v); chk(v == 5, "R12 select readback", v, 5);
        chk(cs == 1, "R12 asserted active high", {31'd0, cs}, 1);
        wr('h08, 32'h1); chk(cs == 0, "R12 asserted active low", {31'd0, cs}, 0);
        wr('h08, 32'h4); chk(cs == 0, "R12 idle active high", {31'd0, cs}, 0);
        wr('h08, 32'h0); chk(cs == 1, "R12 idle active low", {31'd0, cs}, 1);
        // mode 0 style, msb first
        run_xfer("A", 0, 0, 1, 5'd8, 2'd0, 4'd0, 0, 16'd1, 32'h3C, 32'hA7, 1, 0);
        // R10 flag handling
        rd('h00, v);
        wr('h00, v & ~32'h0001_0000);
        chk(irq == 1, "R10 writing 0 keeps flag", {31'd0, irq}, 1);
        wr('h00, v);
        chk(irq == 0, "R10 write back clears irq", {31'd0, irq}, 0);
        rd('h00, v); chk(v[16] == 0, "R10 flag cleared", {31'd0, v[16]}, 0);
        // idle high, drive first edge, lsb first, div 0
        run_xfer("B", 1, 0, 1, 5'd12, 2'd0, 4'd0, 1, 16'd0, 32'h5A3, 32'h9C1, 0, 0);
        // same edge drive and sample, rising
        run_xfer("C", 0, 0, 0, 5'd5, 2'd0, 4'd0, 0, 16'd2, 32'h16, 32'h0B, 1, 0);
        // R5 32-bit encoding, same edge falling, idle high
        run_xfer("D", 1, 1, 1, 5'd0, 2'd0, 4'd0, 0, 16'd0, 32'hDEAD_BEEF, 32'h1234_5678, 1, 0);
        // R8 three words with a gap, writes while busy
        run_xfer("E", 0, 1, 0, 5'd4, 2'd2, 4'd2, 0, 16'd1, 32'h9, 32'h6, 1, 1);
        $display("test done: total=%0d bad=%0d", chk_i + chk_m, bad_i + bad_m);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", chk_i + chk_m + 1, bad_i + bad_m + 1);
        $finish;
    end

endmodule